// File: doc/BRIEF.md
# Enable and power-good pin controller

This block sits between four rail-enable pins, four per-rail power-good inputs and a power-sequencer core. It synchronizes the pins and turns them into per-rail enable requests or into sequence start/stop pulses. It also merges the rail power-good signals into one output pin. Its behaviour is set by a configuration byte. The byte is sampled while reset is held and frozen once reset is released, so later changes on the byte input have no effect until the next reset.

The two lowest configuration bits pick the enable mode. In per-rail mode each pin is combined with a software on/off command for its rail. In software-only mode the pins are ignored. In single-pin mode, pin 1 becomes a sequence trigger: it issues a start pulse on a rise and a stop pulse on a fall. A fall that arrives before the sequencer has reported that the start is complete aborts the start at once. The next four bits choose which rails take part in the merged power-good, and bit 6 picks AND or OR merging. An empty selection always gives a low output.

Top module: `rail_pin_top`

## Requirements
- R1: The configuration byte is captured while reset is low and stays frozen after reset is released. Changes on `cfgByte` during operation have no effect. Bit 7 is reserved and has no effect.
- R2: While reset is low, `railEnReq`, `pgMerged`, `pgStatus`, `seqStart`, `seqStop` and `seqAbort` are all 0.
- R3: Mode field bits[1:0] = 00 (per-rail): `railEnReq[i]` equals `enPins[i] & swOn[i]` for every rail i.
- R4: Mode field = 01 (software-only): `railEnReq` equals `swOn` and all enable pins are ignored. In modes 00 and 01, `seqStart`, `seqStop` and `seqAbort` never pulse.
- R5: Mode field = 1x (single-pin): `railEnReq` is 0, and pins 2 to 4 are ignored (they cause no pulses).
- R6: In single-pin mode, a rise on `enPins[0]` gives a one-cycle `seqStart` pulse. It is high on the third rising clock edge after the pin changes.
- R7: In single-pin mode, a fall on `enPins[0]` gives a one-cycle `seqStop` pulse with the same three-edge latency.
- R8: A start is pending from its `seqStart` until `startDone` is high for a cycle or a stop is issued. A stop issued while a start is pending is not delayed, and `seqAbort` pulses in the same cycle as `seqStop`. A stop issued with no pending start leaves `seqAbort` low.
- R9: Bits[5:2] are the rail masks, with bit 2 for rail 1 through bit 5 for rail 4. A value of 1 includes the rail in the merge and 0 excludes it.
- R10: Bit 6 = 0 gives the AND of the included rails on `pgMerged`, and bit 6 = 1 gives their OR.
- R11: When all four mask bits are 0, `pgMerged` is 0 whatever the value of bit 6.
- R12: `pgStatus` carries the synchronized per-rail power-good values regardless of the masks.
- R13: A change on `pgIn` reaches `pgMerged` and `pgStatus` on the third rising clock edge after it (two synchronizer stages plus an output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; the configuration is sampled while it is low |
| cfgByte | input | NUM_RAILS+4 (8) | Configuration byte: mode[1:0], masks[5:2], merge select[6], reserved[7] |
| enPins | input | NUM_RAILS (4) | Asynchronous rail enable pins |
| swOn | input | NUM_RAILS (4) | Software on/off command per rail |
| pgIn | input | NUM_RAILS (4) | Asynchronous per-rail power-good inputs |
| startDone | input | 1 | Sequencer reports the start sequence is complete |
| railEnReq | output | NUM_RAILS (4) | Per-rail enable request |
| seqStart | output | 1 | One-cycle start-sequence request |
| seqStop | output | 1 | One-cycle stop-sequence request |
| seqAbort | output | 1 | Pulses with seqStop when the stop cuts short a pending start |
| pgMerged | output | 1 | Merged power-good pin |
| pgStatus | output | NUM_RAILS (4) | Synchronized, unmasked per-rail power-good |

## Verification
The bench builds the block with its defaults: NUM_RAILS = 4 and SYNC_STAGES = 2. This gives the full 8-bit configuration byte, so random reset-time bytes cover every mode, the reserved bit, single-rail masks, the all-masked case and both merge functions. With two synchronizer stages the pin-to-output latency is three edges, and the directed cases pin that latency down exactly. The directed cases also cover start-done and abort ordering in single-pin mode.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  typedef enum logic [1:0] {
    MODE_PER_RAIL = 2'b00,
    MODE_SW_ONLY  = 2'b01,
    MODE_SINGLE   = 2'b10
  } enMode_e;

  // strobes from the control module to the datapath
  typedef struct packed {
    logic startStb;
    logic stopStb;
    logic abortStb;
    logic perRail;
    logic swOnly;
  } ctrlStb_t;

  function automatic enMode_e decodeMode(input logic [1:0] field);
    if (field[1])      return MODE_SINGLE;
    else if (field[0]) return MODE_SW_ONLY;
    else               return MODE_PER_RAIL;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/seq_control.sv
module seq_control
  import rpc_pkg::*;
#(
  parameter int NUM_RAILS = 4,
  localparam int CFG_W    = NUM_RAILS + 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CFG_W-1:0]     cfgByte,
  input  logic                 en1Sync,
  input  logic                 startDone,
  output ctrlStb_t             stb,
  output logic [NUM_RAILS-1:0] railMask,
  output logic                 orSel
);

  localparam int MASK_LSB = 2;
  localparam int OR_BIT   = MASK_LSB + NUM_RAILS;

  // reserved msb is not kept
  logic [CFG_W-2:0] cfgReg;
  enMode_e          mode;
  logic             prevEn;
  logic             startPend;
  logic             isSingle;

  always_ff @(posedge clk) begin
    if (!rstN) cfgReg <= cfgByte[CFG_W-2:0];
  end

  assign mode     = decodeMode(cfgReg[1:0]);
  assign isSingle = (mode == MODE_SINGLE);
  assign railMask = cfgReg[OR_BIT-1:MASK_LSB];
  assign orSel    = cfgReg[OR_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) prevEn <= 1'b0;
    else       prevEn <= en1Sync;
  end

  always_comb begin
    stb          = '0;
    stb.perRail  = (mode == MODE_PER_RAIL);
    stb.swOnly   = (mode == MODE_SW_ONLY);
    stb.startStb = isSingle &&  en1Sync && !prevEn;
    stb.stopStb  = isSingle && !en1Sync &&  prevEn;
    stb.abortStb = stb.stopStb && startPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             startPend <= 1'b0;
    else if (stb.stopStb)  startPend <= 1'b0;
    else if (stb.startStb) startPend <= 1'b1;
    else if (startDone)    startPend <= 1'b0;
  end

  // R1
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(cfgReg));

  // R8
  start_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.startStb |=> startPend);

  // R8
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.stopStb |=> !startPend);

endmodule

// File: rtl/pg_datapath.sv
module pg_datapath
  import rpc_pkg::*;
#(
  parameter int NUM_RAILS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStb_t             stb,
  input  logic [NUM_RAILS-1:0] railMask,
  input  logic                 orSel,
  input  logic [NUM_RAILS-1:0] enSync,
  input  logic [NUM_RAILS-1:0] swOn,
  input  logic [NUM_RAILS-1:0] pgSync,
  output logic [NUM_RAILS-1:0] railEnReq,
  output logic                 seqStart,
  output logic                 seqStop,
  output logic                 seqAbort,
  output logic                 pgMerged,
  output logic [NUM_RAILS-1:0] pgStatus
);

  logic [NUM_RAILS-1:0] enNext;
  logic                 mergeAnd;
  logic                 mergeOr;
  logic                 mergeNext;

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    always_comb begin
      if (stb.perRail)     enNext[r] = enSync[r] & swOn[r];
      else if (stb.swOnly) enNext[r] = swOn[r];
      else                 enNext[r] = 1'b0;
    end
  end

  always_comb begin
    mergeAnd  = &(pgSync | ~railMask);
    mergeOr   = |(pgSync & railMask);
    mergeNext = (|railMask) && (orSel ? mergeOr : mergeAnd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      railEnReq <= '0;
      seqStart  <= 1'b0;
      seqStop   <= 1'b0;
      seqAbort  <= 1'b0;
      pgMerged  <= 1'b0;
      pgStatus  <= '0;
    end else begin
      railEnReq <= enNext;
      seqStart  <= stb.startStb;
      seqStop   <= stb.stopStb;
      seqAbort  <= stb.abortStb;
      pgMerged  <= mergeNext;
      pgStatus  <= pgSync;
    end
  end

  // R2
  rst_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (railEnReq == '0 && !pgMerged && !seqStart && !seqStop && !seqAbort));

  // R11
  allmask_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (railMask == '0) |=> !pgMerged);

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |=> !seqStart);

  // R4
  no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.perRail || stb.swOnly) |=> (!seqStart && !seqStop && !seqAbort));

  // R5
  single_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.perRail && !stb.swOnly) |=> (railEnReq == '0));

  // R8
  abort_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqAbort |-> seqStop);

endmodule

// File: rtl/rail_pin_top.sv
module rail_pin_top
  import rpc_pkg::*;
#(
  parameter int NUM_RAILS   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CFG_W      = NUM_RAILS + 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CFG_W-1:0]     cfgByte,
  input  logic [NUM_RAILS-1:0] enPins,
  input  logic [NUM_RAILS-1:0] swOn,
  input  logic [NUM_RAILS-1:0] pgIn,
  input  logic                 startDone,
  output logic [NUM_RAILS-1:0] railEnReq,
  output logic                 seqStart,
  output logic                 seqStop,
  output logic                 seqAbort,
  output logic                 pgMerged,
  output logic [NUM_RAILS-1:0] pgStatus
);

  logic [NUM_RAILS-1:0] enSync;
  logic [NUM_RAILS-1:0] pgSync;
  logic [NUM_RAILS-1:0] railMask;
  logic                 orSel;
  ctrlStb_t             stb;

  pin_sync #(.WIDTH(NUM_RAILS), .STAGES(SYNC_STAGES)) u_enSync (
    .clk(clk), .rstN(rstN), .asyncIn(enPins), .syncOut(enSync));

  pin_sync #(.WIDTH(NUM_RAILS), .STAGES(SYNC_STAGES)) u_pgSync (
    .clk(clk), .rstN(rstN), .asyncIn(pgIn), .syncOut(pgSync));

  seq_control #(.NUM_RAILS(NUM_RAILS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgByte(cfgByte), .en1Sync(enSync[0]),
    .startDone(startDone), .stb(stb), .railMask(railMask), .orSel(orSel));

  pg_datapath #(.NUM_RAILS(NUM_RAILS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .railMask(railMask), .orSel(orSel),
    .enSync(enSync), .swOn(swOn), .pgSync(pgSync), .railEnReq(railEnReq),
    .seqStart(seqStart), .seqStop(seqStop), .seqAbort(seqAbort),
    .pgMerged(pgMerged), .pgStatus(pgStatus));

endmodule

// File: tb/tb_rail_pin_top.sv
module tb_rail_pin_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] cfgByte;
  logic [3:0] enPins, swOn, pgIn;
  logic       startDone;
  logic [3:0] railEnReq, pgStatus;
  logic       seqStart, seqStop, seqAbort, pgMerged;

  int checks = 0;
  int errors = 0;
  int nStart = 0, nStop = 0, nAbort = 0;
  int xStart = 0, xStop = 0, xAbort = 0;
  logic [7:0] liveCfg;
  logic       prevEn0, pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_pin_top dut (
    .clk(clk), .rstN(rstN), .cfgByte(cfgByte), .enPins(enPins), .swOn(swOn),
    .pgIn(pgIn), .startDone(startDone), .railEnReq(railEnReq),
    .seqStart(seqStart), .seqStop(seqStop), .seqAbort(seqAbort),
    .pgMerged(pgMerged), .pgStatus(pgStatus));

  always @(posedge clk) begin
    if (rstN) begin
      if (seqStart) nStart++;
      if (seqStop)  nStop++;
      if (seqAbort) nAbort++;
    end
  end

  function automatic logic [3:0] expEn(input logic [7:0] c, input logic [3:0] e,
                                       input logic [3:0] s);
    if (c[1])      return 4'b0000;
    else if (c[0]) return s;
    else           return e & s;
  endfunction

  function automatic logic expPg(input logic [7:0] c, input logic [3:0] p);
    logic [3:0] m;
    m = c[5:2];
    if (m == 4'b0000) return 1'b0;
    if (c[6]) return |(p & m);
    return &(p | ~m);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic doReset(input logic [7:0] c);
    @(negedge clk);
    rstN = 1'b0; cfgByte = c; enPins = 4'h0; startDone = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    liveCfg = c; prevEn0 = 1'b0; pend = 1'b0;
  endtask

  // apply a vector, update pulse expectations, wait until settled
  task automatic applyVec(input logic [3:0] e, input logic [3:0] s, input logic [3:0] p);
    @(negedge clk);
    enPins = e; swOn = s; pgIn = p;
    if (liveCfg[1]) begin
      if (e[0] && !prevEn0) begin xStart++; pend = 1'b1; end
      if (!e[0] && prevEn0) begin xStop++; if (pend) xAbort++; pend = 1'b0; end
    end
    prevEn0 = e[0];
    repeat (4) @(negedge clk);
  endtask

  task automatic checkSteady(input string tagSuffix);
    check({"R3/R4/R5 railEnReq ", tagSuffix}, railEnReq, expEn(liveCfg, enPins, swOn));
    check({"R9/R10/R11 pgMerged ", tagSuffix}, pgMerged, expPg(liveCfg, pgIn));
    check({"R12 pgStatus ", tagSuffix}, pgStatus, pgIn);
  endtask

  task automatic checkCounts(input string tagSuffix);
    check({"R6 start count ", tagSuffix}, nStart, xStart);
    check({"R7 stop count ", tagSuffix}, nStop, xStop);
    check({"R8 abort count ", tagSuffix}, nAbort, xAbort);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; cfgByte = 8'h3C; enPins = 4'h0; swOn = 4'h0; pgIn = 4'h0;
    startDone = 1'b0; liveCfg = 8'h3C; prevEn0 = 1'b0; pend = 1'b0;

    // R2: outputs quiet during reset with everything driven high
    @(negedge clk);
    enPins = 4'hF; swOn = 4'hF; pgIn = 4'hF;
    repeat (5) @(negedge clk);
    check("R2 railEnReq in reset", railEnReq, 4'h0);
    check("R2 pgMerged in reset", pgMerged, 1'b0);
    check("R2 pgStatus in reset", pgStatus, 4'h0);
    check("R2 pulses in reset", {seqStart, seqStop, seqAbort}, 3'b000);

    // per-rail mode, AND of all rails
    doReset(8'h3C);
    applyVec(4'h0, 4'hF, 4'h0);
    // R13: exact latency of power-good path
    enPins = 4'h0;
    @(negedge clk); pgIn = 4'hF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R13 pgMerged before third edge", pgMerged, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R13 pgMerged at third edge", pgMerged, 1'b1);
    check("R13 pgStatus at third edge", pgStatus, 4'hF);

    // R3 directed
    applyVec(4'b1010, 4'b1100, 4'hF);
    check("R3 per-rail and", railEnReq, 4'b1000);
    applyVec(4'b0111, 4'b1111, 4'b1110);
    check("R3 per-rail pins", railEnReq, 4'b0111);
    check("R10 and with one low rail", pgMerged, 1'b0);

    // R1: byte changes during operation are ignored
    cfgByte = 8'h41;
    applyVec(4'b0101, 4'b1111, 4'b0001);
    check("R1 mode frozen", railEnReq, 4'b0101);
    check("R1 merge frozen", pgMerged, 1'b0);
    checkCounts("directed per-rail R4");

    // R4 software-only, R10 OR of masked set (rails 1 and 3)
    doReset(8'h55);
    applyVec(4'b0000, 4'b1010, 4'b0100);
    check("R4 pins ignored", railEnReq, 4'b1010);
    check("R9/R10 OR rail 3 included", pgMerged, 1'b1);
    applyVec(4'b1111, 4'b0011, 4'b1010);
    check("R4 pins ignored high", railEnReq, 4'b0011);
    check("R9 excluded rails ignored", pgMerged, 1'b0);

    // R11 all masked, OR selected
    doReset(8'hC0);
    applyVec(4'h0, 4'h0, 4'hF);
    check("R11 all masked forces low", pgMerged, 1'b0);
    check("R12 status unmasked", pgStatus, 4'hF);

    // single-pin mode
    doReset(8'h3E);
    // R6 exact latency and width
    @(negedge clk); enPins = 4'b0001; swOn = 4'hF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R6 no start before third edge", seqStart, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R6 start at third edge", seqStart, 1'b1);
    @(negedge clk);
    check("R6 start one cycle", seqStart, 1'b0);
    xStart++; pend = 1'b1; prevEn0 = 1'b1;
    repeat (2) @(negedge clk);
    // R8 start completes, stop has no abort
    startDone = 1'b1; @(negedge clk); startDone = 1'b0; pend = 1'b0;
    // R7 exact latency
    enPins = 4'b0000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 no stop before third edge", seqStop, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R7 stop at third edge", seqStop, 1'b1);
    check("R8 no abort after done", seqAbort, 1'b0);
    xStop++; prevEn0 = 1'b0;
    repeat (2) @(negedge clk);
    // R8 abort: drop before done
    applyVec(4'b0001, 4'hF, 4'h0);
    applyVec(4'b0000, 4'hF, 4'h0);
    // R5 other pins ignored
    applyVec(4'b1110, 4'hF, 4'h0);
    applyVec(4'b0000, 4'hF, 4'h0);
    check("R5 rail requests idle", railEnReq, 4'h0);
    checkCounts("directed single R5/R8");

    // random phase
    for (int it = 0; it < 40; it++) begin
      doReset(8'($urandom));
      for (int v = 0; v < 12; v++) begin
        cfgByte = 8'($urandom);
        applyVec(4'($urandom), 4'($urandom), 4'($urandom));
        checkSteady("random");
      end
      checkCounts("random");
    end

    finishRun();
  end

endmodule